// File: doc/BRIEF.md
# Root-Hub Port Status and Control Register

This block keeps one 16-bit status and control word for each downstream port of a small full/low-speed root hub. Host software reads and writes the words over a plain single-cycle register bus. Each word shows the live port condition: attached, low-speed, over-current, enabled, suspended, resuming and in reset. It also shows three sticky change flags, which software acknowledges by writing ones to them. Line signalling on the data pair is not modelled. Four event inputs stand in for it for each port: attach (with a speed qualifier), detach, an over-current level and a remote-wake request.

Each write replaces every control field of the addressed port, so software does a read-modify-write. It masks the change flags to zero unless it means to acknowledge them. The control fields are kept by a per-port state machine with these states:

- DISABLED: the reset state.
- ENABLED
- SUSPENDED
- RESUMING: resume signalling is being driven.
- EOP: the timed end-of-resume phase, in which the resume field still reads one.
- RESET: port reset is being driven.

The state machine has these transitions:

- enable: DISABLED to ENABLED, only while attached.
- disable: any enabled state to DISABLED.
- suspend: ENABLED to SUSPENDED.
- unsuspend: SUSPENDED to ENABLED.
- resume-by-software or wake: SUSPENDED to RESUMING.
- resume-end: RESUMING to EOP.
- EOP-done: EOP to ENABLED.
- reset-entry: any state to RESET.
- reset-exit: RESET to DISABLED.
- detach: any state except RESET to DISABLED.

Field map of each word:

| Bit | Field | Access |
|-----|-------|--------|
| 0 | attached | read-only |
| 1 | attach change | write 1 to clear |
| 2 | enable | read/write |
| 3 | enable change | write 1 to clear |
| 4 | suspend | read/write |
| 5 | resume | read/write |
| 6 | reset | read/write |
| 7 | low-speed | read-only |
| 8 | over-current | read-only |
| 9 | over-current change | write 1 to clear |
| 10 | power | read-only, always 1 |
| 15:11 | reserved | read 0 |

Top module: `rhp_root_hub_regs`

## Requirements
- R1: After reset every port word reads 0x0400: only the power bit (bit 10) is set, and `port_chg` is all zero.
- R2: An attach event on a detached port sets bit 0, copies `dev_lowspeed` into bit 7 and sets bit 1. A detach event on an attached port has these effects: it clears bits 0 and 7, it sets bit 1, and on an enabled port it clears bit 2 and sets bit 3.
- R3: Writing 1 to bit 1, 3 or 9 clears that flag, and writing 0 leaves it unchanged. An event that sets a flag in the same cycle as a clearing write wins.
- R4: Bits 15:11 always read 0. Writes have no effect on bits 0, 7, 8 and 10.
- R5: Writing bit 2 = 1 enables the port only if it is attached. Writing bit 2 = 0 disables it and clears bits 4 and 5 without setting bit 3.
- R6: Writing bit 4 = 1 on an enabled port suspends it. On a disabled port the write is ignored.
- R7: Writing bit 5 = 1 is ignored while bit 2 is 0. On a suspended port it starts resume signalling, so bit 5 reads 1.
- R8: A wake event sets bit 5 only on a suspended, enabled port. Otherwise it has no effect.
- R9: Writing bit 5 = 0 while resuming leaves bit 5 reading 1 for EOP_CYCLES clock cycles. After that, bits 5 and 4 read 0 and bit 2 stays 1.
- R10: Writing bit 6 = 1 puts the port in reset, with bit 6 set and bit 2 clear. If the port was enabled, bit 3 is also set.
- R11: Writing bit 6 = 0 while in reset ends the reset, clears bit 6, sets bit 1 and leaves the port disabled.
- R12: Bit 8 follows `dev_overcur` one clock later. Bit 9 is set on every change of that input.
- R13: `port_chg[i]` is high exactly when port i has any of bits 1, 3 or 9 set.
- R14: A write or event on one port leaves the other port's word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Port select for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Word of the selected port (combinational) |
| dev_connect | input | NUM_PORTS | Attach event pulse, per port |
| dev_lowspeed | input | NUM_PORTS | Low-speed qualifier, sampled with attach |
| dev_disconnect | input | NUM_PORTS | Detach event pulse, per port |
| dev_overcur | input | NUM_PORTS | Over-current level, per port |
| dev_wake | input | NUM_PORTS | Remote-wake event pulse, per port |
| port_chg | output | NUM_PORTS | Any change flag pending, per port |

## Verification
The properties assume that attach and detach never pulse together on one port. They also assume that writes come from read-modify-write sequences, so that a write meant for one field does not drop the enable bit by accident. The bench drives every event as a one-cycle pulse on the falling clock edge. It builds each write value from the last expected word, and it pairs a bus write with a port event only in the single check of flag-set priority. Sweeps over the read-only and reserved fields, and over every mask of the three change flags, are done on a port whose state the bench has just fixed.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

    localparam int DATA_W = 16;

    // Field positions inside a port word
    localparam int B_CONN = 0;
    localparam int B_CCHG = 1;
    localparam int B_EN   = 2;
    localparam int B_ECHG = 3;
    localparam int B_SUSP = 4;
    localparam int B_RSM  = 5;
    localparam int B_RST  = 6;
    localparam int B_LS   = 7;
    localparam int B_OVC  = 8;
    localparam int B_OCHG = 9;
    localparam int B_PWR  = 10;
    localparam int N_USED = 11;

    // Number of sticky change flags
    localparam int N_CHG = 3;

    typedef enum logic [2:0] {
        PS_DISABLED  = 3'd0,
        PS_ENABLED   = 3'd1,
        PS_SUSPENDED = 3'd2,
        PS_RESUMING  = 3'd3,
        PS_EOP       = 3'd4,
        PS_RESET     = 3'd5
    } port_state_e;

    // Control fields taken from a write
    typedef struct packed {
        logic rst;
        logic rsm;
        logic susp;
        logic en;
    } port_ctl_t;

endpackage

// File: rtl/rhp_w1c_bit.sv
module rhp_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Setting has priority over a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/rhp_port_flags.sv
module rhp_port_flags
    import rhp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [N_CHG-1:0] clr_req,   // {ovc chg, enable chg, attach chg}
    input  logic             ev_conn,
    input  logic             ev_ls,
    input  logic             ev_disc,
    input  logic             oc_in,
    input  logic             en_lost,
    input  logic             rst_exit,
    output logic             conn,
    output logic             ls,
    output logic             ovc,
    output logic             cchg,
    output logic             echg,
    output logic             ochg,
    output logic             disc_eff
);

    logic conn_q, ls_q, ovc_q;
    logic conn_set;
    logic [N_CHG-1:0] set_v, q_v;

    assign disc_eff = ev_disc && conn_q;
    assign conn_set = ev_conn && !ev_disc && !conn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            ls_q   <= 1'b0;
            ovc_q  <= 1'b0;
        end else begin
            ovc_q <= oc_in;
            if (disc_eff) begin
                conn_q <= 1'b0;
                ls_q   <= 1'b0;
            end else if (conn_set) begin
                conn_q <= 1'b1;
                ls_q   <= ev_ls;
            end
        end
    end

    assign set_v[0] = conn_set || disc_eff || rst_exit;
    assign set_v[1] = en_lost;
    assign set_v[2] = (oc_in != ovc_q);

    for (genvar k = 0; k < N_CHG; k++) begin : g_chg
        rhp_w1c_bit u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[k]),
            .clr_i (wr_sel && clr_req[k]),
            .q_o   (q_v[k])
        );
    end

    assign conn = conn_q;
    assign ls   = ls_q;
    assign ovc  = ovc_q;
    assign cchg = q_v[0];
    assign echg = q_v[1];
    assign ochg = q_v[2];

endmodule

// File: rtl/rhp_port_fsm.sv
module rhp_port_fsm
    import rhp_pkg::*;
#(
    parameter int EOP_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_sel,
    input  port_ctl_t ctl,
    input  logic      conn,
    input  logic      disc,
    input  logic      wake,
    output logic      en,
    output logic      susp,
    output logic      rsm,
    output logic      rst_act,
    output logic      en_lost,
    output logic      rst_exit
);

    localparam int CNT_W = (EOP_CYCLES > 1) ? $clog2(EOP_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EOP_CYCLES - 1);

    port_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_DISABLED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        en_lost  = 1'b0;
        rst_exit = 1'b0;
        if (st_q == PS_RESET) begin
            if (wr_sel && !ctl.rst) begin
                st_d     = PS_DISABLED;
                rst_exit = 1'b1;
            end
        end else if (disc) begin
            st_d    = PS_DISABLED;
            en_lost = (st_q != PS_DISABLED);
        end else if (wr_sel && ctl.rst) begin
            st_d    = PS_RESET;
            en_lost = (st_q != PS_DISABLED);
        end else begin
            unique case (st_q)
                PS_DISABLED: begin
                    if (wr_sel && ctl.en && conn)
                        st_d = PS_ENABLED;
                end
                PS_ENABLED: begin
                    if (wr_sel) begin
                        if (!ctl.en)
                            st_d = PS_DISABLED;
                        else if (ctl.susp)
                            st_d = PS_SUSPENDED;
                    end
                end
                PS_SUSPENDED: begin
                    if (wr_sel) begin
                        if (!ctl.en)
                            st_d = PS_DISABLED;
                        else if (ctl.rsm)
                            st_d = PS_RESUMING;
                        else if (!ctl.susp)
                            st_d = PS_ENABLED;
                    end else if (wake) begin
                        st_d = PS_RESUMING;
                    end
                end
                PS_RESUMING: begin
                    if (wr_sel) begin
                        if (!ctl.en) begin
                            st_d = PS_DISABLED;
                        end else if (!ctl.rsm) begin
                            st_d  = PS_EOP;
                            cnt_d = CNT_LOAD;
                        end
                    end
                end
                PS_EOP: begin
                    if (wr_sel && !ctl.en)
                        st_d = PS_DISABLED;
                    else if (cnt_q == '0)
                        st_d = PS_ENABLED;
                    else
                        cnt_d = cnt_q - 1'b1;
                end
                default: st_d = PS_DISABLED;
            endcase
        end
    end

    // Output decode
    always_comb begin
        en      = 1'b0;
        susp    = 1'b0;
        rsm     = 1'b0;
        rst_act = 1'b0;
        unique case (st_q)
            PS_DISABLED:  ;
            PS_ENABLED:   en = 1'b1;
            PS_SUSPENDED: begin en = 1'b1; susp = 1'b1; end
            PS_RESUMING:  begin en = 1'b1; susp = 1'b1; rsm = 1'b1; end
            PS_EOP:       begin en = 1'b1; susp = 1'b1; rsm = 1'b1; end
            PS_RESET:     rst_act = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/rhp_root_hub_regs.sv
module rhp_root_hub_regs
    import rhp_pkg::*;
#(
    parameter int NUM_PORTS  = 2,
    parameter int EOP_CYCLES = 8,
    localparam int ADDR_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_PORTS-1:0] dev_connect,
    input  logic [NUM_PORTS-1:0] dev_lowspeed,
    input  logic [NUM_PORTS-1:0] dev_disconnect,
    input  logic [NUM_PORTS-1:0] dev_overcur,
    input  logic [NUM_PORTS-1:0] dev_wake,
    output logic [NUM_PORTS-1:0] port_chg
);

    localparam int RSV_W = DATA_W - N_USED;

    logic [NUM_PORTS-1:0] p_wsel, p_en, p_susp, p_rsm, p_rst;
    logic [NUM_PORTS-1:0] p_conn, p_ls, p_ovc, p_cchg, p_echg, p_ochg;
    logic [NUM_PORTS-1:0] p_disc, p_lost, p_rexit;
    logic [NUM_PORTS-1:0][DATA_W-1:0] word;

    port_ctl_t        wr_ctl;
    logic [N_CHG-1:0] wr_clr;
    logic             wdata_unused;

    assign wr_ctl = '{rst: bus_wdata[B_RST], rsm: bus_wdata[B_RSM],
                      susp: bus_wdata[B_SUSP], en: bus_wdata[B_EN]};
    assign wr_clr = {bus_wdata[B_OCHG], bus_wdata[B_ECHG], bus_wdata[B_CCHG]};
    assign wdata_unused = ^{bus_wdata[DATA_W-1:B_PWR], bus_wdata[B_OVC],
                            bus_wdata[B_LS], bus_wdata[B_CONN]};

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign p_wsel[i] = bus_wr && (int'(bus_addr) == i);

        rhp_port_flags u_flags (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (p_wsel[i]),
            .clr_req  (wr_clr),
            .ev_conn  (dev_connect[i]),
            .ev_ls    (dev_lowspeed[i]),
            .ev_disc  (dev_disconnect[i]),
            .oc_in    (dev_overcur[i]),
            .en_lost  (p_lost[i]),
            .rst_exit (p_rexit[i]),
            .conn     (p_conn[i]),
            .ls       (p_ls[i]),
            .ovc      (p_ovc[i]),
            .cchg     (p_cchg[i]),
            .echg     (p_echg[i]),
            .ochg     (p_ochg[i]),
            .disc_eff (p_disc[i])
        );

        rhp_port_fsm #(
            .EOP_CYCLES (EOP_CYCLES)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (p_wsel[i]),
            .ctl      (wr_ctl),
            .conn     (p_conn[i]),
            .disc     (p_disc[i]),
            .wake     (dev_wake[i]),
            .en       (p_en[i]),
            .susp     (p_susp[i]),
            .rsm      (p_rsm[i]),
            .rst_act  (p_rst[i]),
            .en_lost  (p_lost[i]),
            .rst_exit (p_rexit[i])
        );

        assign word[i] = {{RSV_W{1'b0}}, 1'b1, p_ochg[i], p_ovc[i], p_ls[i],
                          p_rst[i], p_rsm[i], p_susp[i], p_echg[i], p_en[i],
                          p_cchg[i], p_conn[i]};

        assign port_chg[i] = p_cchg[i] | p_echg[i] | p_ochg[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) < NUM_PORTS)
            bus_rdata = word[bus_addr];
    end

endmodule

// File: rtl/rhp_regs_chk.sv
module rhp_regs_chk #(
    parameter int NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] p_wsel,
    input logic                 clr_cchg,
    input logic [NUM_PORTS-1:0] p_en,
    input logic [NUM_PORTS-1:0] p_susp,
    input logic [NUM_PORTS-1:0] p_rsm,
    input logic [NUM_PORTS-1:0] p_rst,
    input logic [NUM_PORTS-1:0] p_conn,
    input logic [NUM_PORTS-1:0] p_cchg,
    input logic [NUM_PORTS-1:0] p_echg
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        // R3: a pending attach-change flag survives any cycle without a clearing write
        a_r3_w1c_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (p_cchg[i] && !(p_wsel[i] && clr_cchg)) |=> p_cchg[i]);

        // R2: losing the attachment raises the flag and drops enable
        a_r2_detach: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(p_conn[i]) |-> (p_cchg[i] && !p_en[i]));

        // R5: a disabled port is never suspended
        a_r5_dis_no_susp: assert property (@(posedge clk) disable iff (!rst_n)
            !p_en[i] |-> !p_susp[i]);

        // R7: resume is only shown on an enabled, suspended port
        a_r7_rsm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            p_rsm[i] |-> (p_en[i] && p_susp[i]));

        // R9: when resume ends on a live port, suspend has ended too
        a_r9_eop_exit: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(p_rsm[i]) && p_en[i]) |-> !p_susp[i]);

        // R10: reset entry from an enabled port flags the enable change
        a_r10_rst_entry: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(p_rst[i]) && $past(p_en[i])) |-> p_echg[i]);

        // R11: reset exit flags an attach change
        a_r11_rst_exit: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(p_rst[i]) |-> p_cchg[i]);
    end

endmodule

bind rhp_root_hub_regs rhp_regs_chk #(
    .NUM_PORTS (NUM_PORTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .p_wsel   (p_wsel),
    .clr_cchg (bus_wdata[1]),
    .p_en     (p_en),
    .p_susp   (p_susp),
    .p_rsm    (p_rsm),
    .p_rst    (p_rst),
    .p_conn   (p_conn),
    .p_cchg   (p_cchg),
    .p_echg   (p_echg)
);

// File: tb/sim_rhp_root_hub_regs.sv
`timescale 1ns/1ps
module sim_rhp_root_hub_regs;

    localparam int NP  = 2;
    localparam int EOP = 8;
    localparam int AW  = 1;

    // Field values (see BRIEF field map)
    localparam logic [15:0] F_CONN = 16'h0001, F_CCHG = 16'h0002, F_EN = 16'h0004,
                            F_ECHG = 16'h0008, F_SUSP = 16'h0010, F_RSM = 16'h0020,
                            F_RST  = 16'h0040, F_LS   = 16'h0080, F_OVC = 16'h0100,
                            F_OCHG = 16'h0200, F_PWR  = 16'h0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NP-1:0] dev_connect = '0, dev_lowspeed = '0, dev_disconnect = '0;
    logic [NP-1:0] dev_overcur = '0, dev_wake = '0;
    logic [NP-1:0] port_chg;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rhp_root_hub_regs #(.NUM_PORTS(NP), .EOP_CYCLES(EOP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_connect(dev_connect), .dev_lowspeed(dev_lowspeed),
        .dev_disconnect(dev_disconnect), .dev_overcur(dev_overcur),
        .dev_wake(dev_wake), .port_chg(port_chg)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rdchk(input int p, input logic [15:0] exp, input string tag);
        bus_addr = AW'(p);
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(input int p, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(p); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ev_conn(input int p, input logic spd);
        @(negedge clk);
        dev_connect[p] = 1'b1; dev_lowspeed[p] = spd;
        @(negedge clk);
        dev_connect[p] = 1'b0; dev_lowspeed[p] = 1'b0;
    endtask

    task automatic ev_disc(input int p);
        @(negedge clk);
        dev_disconnect[p] = 1'b1;
        @(negedge clk);
        dev_disconnect[p] = 1'b0;
    endtask

    task automatic ev_wake(input int p);
        @(negedge clk);
        dev_wake[p] = 1'b1;
        @(negedge clk);
        dev_wake[p] = 1'b0;
    endtask

    task automatic set_oc(input int p, input logic v);
        @(negedge clk);
        dev_overcur[p] = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] p0_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdchk(0, F_PWR, "R1 port0 reset word");
        rdchk(1, F_PWR, "R1 port1 reset word");
        chk("R1 port_chg after reset", {14'b0, port_chg}, 16'h0000);

        // R2 attach, low speed
        ev_conn(0, 1'b1);
        rdchk(0, F_PWR | F_CONN | F_CCHG | F_LS, "R2 attach low-speed");
        chk("R13 port_chg on attach", {14'b0, port_chg}, 16'h0001);
        rdchk(1, F_PWR, "R14 port1 untouched by port0 attach");

        // R3 write-one-to-clear
        wr(0, 16'h0000);
        rdchk(0, F_PWR | F_CONN | F_CCHG | F_LS, "R3 zero write keeps flag");
        wr(0, F_CCHG);
        rdchk(0, F_PWR | F_CONN | F_LS, "R3 one write clears flag");
        chk("R13 port_chg cleared", {14'b0, port_chg}, 16'h0000);

        // R5 enable, R6 suspend, R8 wake, R9 end of resume
        wr(0, F_EN);
        rdchk(0, F_PWR | F_CONN | F_LS | F_EN, "R5 enable attached port");
        wr(0, F_EN | F_SUSP);
        rdchk(0, F_PWR | F_CONN | F_LS | F_EN | F_SUSP, "R6 suspend enabled port");
        ev_wake(0);
        rdchk(0, F_PWR | F_CONN | F_LS | F_EN | F_SUSP | F_RSM, "R8 wake sets resume");
        wr(0, F_EN | F_SUSP);
        for (int j = 0; j < EOP; j++) begin
            rdchk(0, F_PWR | F_CONN | F_LS | F_EN | F_SUSP | F_RSM, "R9 resume held during EOP");
            @(negedge clk);
        end
        rdchk(0, F_PWR | F_CONN | F_LS | F_EN, "R9 resume and suspend end after EOP");

        // R7 resume by write, R5 disable clears suspend without enable change
        wr(0, F_EN | F_SUSP);
        wr(0, F_EN | F_SUSP | F_RSM);
        rdchk(0, F_PWR | F_CONN | F_LS | F_EN | F_SUSP | F_RSM, "R7 resume write on suspended port");
        wr(0, 16'h0000);
        rdchk(0, F_PWR | F_CONN | F_LS, "R5 disable clears suspend and resume");
        wr(0, F_SUSP | F_RSM);
        rdchk(0, F_PWR | F_CONN | F_LS, "R7 resume and R6 suspend ignored while disabled");

        // R5 enable refused on detached port
        wr(1, F_EN);
        rdchk(1, F_PWR, "R5 enable refused when detached");

        // R10 / R11 reset on enabled port
        wr(0, F_EN);
        wr(0, F_EN | F_RST);
        rdchk(0, F_PWR | F_CONN | F_LS | F_RST | F_ECHG, "R10 reset entry from enabled");
        wr(0, 16'h0000);
        rdchk(0, F_PWR | F_CONN | F_LS | F_ECHG | F_CCHG, "R11 reset exit");
        wr(0, F_CCHG | F_ECHG);
        // reset on disabled port
        wr(0, F_RST);
        rdchk(0, F_PWR | F_CONN | F_LS | F_RST, "R10 reset entry from disabled");
        wr(0, 16'h0000);
        rdchk(0, F_PWR | F_CONN | F_LS | F_CCHG, "R11 reset exit leaves port disabled");
        wr(0, F_CCHG);

        // R2 detach of enabled port
        wr(0, F_EN);
        ev_disc(0);
        rdchk(0, F_PWR | F_CCHG | F_ECHG, "R2 detach of enabled port");
        wr(0, F_CCHG | F_ECHG);
        rdchk(0, F_PWR, "R3 both flags cleared");

        // R12 over-current
        set_oc(0, 1'b1);
        rdchk(0, F_PWR | F_OVC | F_OCHG, "R12 over-current rise");
        chk("R13 port_chg on over-current", {14'b0, port_chg}, 16'h0001);
        wr(0, F_OCHG);
        rdchk(0, F_PWR | F_OVC, "R12 change cleared, level kept");
        set_oc(0, 1'b0);
        rdchk(0, F_PWR | F_OCHG, "R12 over-current fall");
        wr(0, F_OCHG);

        // R8 wake ignored on non-suspended port
        ev_conn(0, 1'b0);
        wr(0, F_EN | F_CCHG);
        ev_wake(0);
        rdchk(0, F_PWR | F_CONN | F_EN, "R8 wake ignored when not suspended");

        // R3 set wins over clearing write in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = F_EN | F_CCHG;
        dev_disconnect[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; dev_disconnect[0] = 1'b0;
        rdchk(0, F_PWR | F_CCHG | F_ECHG, "R3 event set beats clearing write");
        wr(0, F_CCHG | F_ECHG);

        // R4 sweep over read-only and reserved fields on port1, R14 port0 unchanged
        bus_addr = 1'b0; #0.5; p0_before = bus_rdata;
        for (int k = 0; k < 512; k++) begin
            wr(1, 16'(k << 7));
            rdchk(1, F_PWR, "R4 read-only and reserved fields unaffected");
            rdchk(0, p0_before, "R14 port0 unchanged by port1 writes");
        end

        // R3 sweep over every acknowledge mask
        for (int m = 0; m < 8; m++) begin
            logic [15:0] mask, flags;
            mask = (m[0] ? F_CCHG : 16'h0) | (m[1] ? F_ECHG : 16'h0) | (m[2] ? F_OCHG : 16'h0);
            flags = F_CCHG | F_ECHG | F_OCHG;
            ev_conn(1, 1'b0);
            wr(1, F_EN);
            set_oc(1, 1'b1);
            set_oc(1, 1'b0);
            ev_disc(1);
            rdchk(1, F_PWR | flags, "R3 all flags pending");
            wr(1, mask);
            rdchk(1, F_PWR | (flags & ~mask), "R3 mask clears only written ones");
            chk("R13 port_chg follows flags", {14'b0, port_chg},
                {14'b0, (mask != flags), 1'b0});
            wr(1, flags);
        end

        finish_run();
    end

endmodule